// File: doc/BRIEF.md
# Snoop Inquire Response Logic

This block answers snoop inquiries from another bus master. When the inquiry strobe is sampled high, the block captures the snooped line address. In the next clock it looks that address up in two small direct-mapped tag arrays, one for the instruction side and one for the data side. One clock after that it updates two active-low result outputs. `hit_n` reports whether either array holds a valid copy of the line. `hitm_n` reports that the data array holds the line in a modified state.

`hit_n` is a registered status. It changes only when an inquiry result arrives and otherwise keeps its value. `hitm_n`, once asserted, holds the other master off until the writeback of the modified line has finished. Completion is signalled by a one-clock `wb_done` pulse. That pulse releases `hitm_n` and marks the pending line clean. Lines enter the arrays through a simple fill port that carries the full line address, the target side, a valid flag and a dirty flag. The bus transfers that perform the writeback are handled elsewhere.

Top module: `snoop_inquire_resp`

## Requirements
- R1: While `rst_n` is low, and after its release until the first inquiry result, `hit_n` and `hitm_n` are both 1 and every tag entry is invalid.
- R2: A strobe sampled at clock edge N whose line is valid in either array drives `hit_n` to 0 after edge N+2.
- R3: A strobe sampled at edge N whose line is valid in neither array drives `hit_n` to 1 after edge N+2.
- R4: `hit_n` changes only at an edge that delivers an inquiry result. At every other edge it keeps its value.
- R5: When the inquiry hits a dirty line of the data array, `hitm_n` goes to 0 at the same edge where `hit_n` takes that result.
- R6: `hitm_n` stays 0 until `wb_done` is sampled high. It returns to 1 at that edge. The pending data line becomes clean, so a later inquiry of that line reports a hit with `hitm_n` = 1.
- R7: A strobe sampled at edge N+1 or N+2 after an accepted strobe at edge N is ignored. It produces no result, and only the lookup accepted at edge N reaches the outputs.
- R8: The instruction array keeps no dirty state, and a clean data line raises no modified result. A hit on either leaves `hitm_n` at 1.
- R9: A fill writes the tag and valid flag of one entry. A fill with `fill_valid` = 0 invalidates the entry. A fill with a new tag replaces the old line, so the old line then misses.
- R10: Lines are 32 bytes. The set index is address bits [7:5], the tag is bits [31:8], and bits [4:0] have no effect on a lookup.
- R11: A `wb_done` pulse while `hitm_n` is 1 has no effect. When a new modified result arrives at the same edge as `wb_done`, `hitm_n` stays 0 and only the previously pending line is made clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inq_strobe | input | 1 | Inquiry address valid, sampled on the rising edge |
| inq_addr | input | 32 | Snooped byte address |
| fill_en | input | 1 | Write one tag entry |
| fill_dside | input | 1 | Fill target: 1 selects the data array, 0 the instruction array |
| fill_addr | input | 32 | Byte address of the line being filled |
| fill_valid | input | 1 | Valid flag written by the fill |
| fill_dirty | input | 1 | Dirty flag written by a data-side fill |
| wb_done | input | 1 | One-clock pulse: the pending modified line has been written back |
| hit_n | output | 1 | Active-low inquiry hit, held between inquiries |
| hitm_n | output | 1 | Active-low hit to a modified data line, held until writeback completes |

## Verification
The assertions watch, on every clock, the strobe-to-lookup-to-result cadence and the refusal of strobes while the pipeline is busy. They also check that `hit_n` never moves without a result, that a modified result asserts both outputs together, and that `hitm_n` is held and released only by `wb_done`. The contents of the tag arrays cannot be judged from those local relations. Only the bench scenarios, measured against the reference model, can show that the right lines hit or miss. That covers replacement and invalidation by fills, the ignored offset bits, the dirty bit being cleared by a writeback, and the coincidence of a new modified result with `wb_done`.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic {SIDE_INSTR = 1'b0, SIDE_DATA = 1'b1} side_e;
  localparam int NUM_SIDES = 2;
endpackage

// File: rtl/snoop_tag_array.sv
module snoop_tag_array #(
  parameter int IDX_W       = 3,
  parameter int TAG_W       = 24,
  parameter bit TRACK_DIRTY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic             rd_hit_dirty
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= wr_valid;
  end

  // Tags need no reset: the valid bit masks them.
  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

  generate
    if (TRACK_DIRTY) begin : g_dirty
      logic [DEPTH-1:0] dirty_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dirty_q <= '0;
        end else begin
          for (int i = 0; i < DEPTH; i++) begin
            // A fill to an entry wins over a writeback clear of it.
            if (wr_en && (wr_idx == IDX_W'(i)))        dirty_q[i] <= wr_dirty && wr_valid;
            else if (clr_en && (clr_idx == IDX_W'(i))) dirty_q[i] <= 1'b0;
          end
        end
      end
      assign rd_hit_dirty = rd_hit && dirty_q[rd_idx];
    end else begin : g_clean
      logic unused_dirty_inputs;
      assign unused_dirty_inputs = ^{wr_dirty, clr_en, clr_idx};
      assign rd_hit_dirty = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/snoop_inq_pipe.sv
module snoop_inq_pipe #(
  parameter int LINE_W = 27,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [LINE_W-1:0] line_in,
  input  logic              lk_hit,
  input  logic              lk_dirty,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              inq_accept,
  output logic              lookup_fire,
  output logic [LINE_W-1:0] look_line,
  output logic              result_load,
  output logic              res_hit,
  output logic              res_mod,
  output logic [IDX_W-1:0]  res_idx
);
  // A strobe is taken only when neither stage holds a lookup.
  assign inq_accept = strobe && !lookup_fire && !result_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lookup_fire <= 1'b0;
      look_line   <= '0;
      result_load <= 1'b0;
      res_hit     <= 1'b0;
      res_mod     <= 1'b0;
      res_idx     <= '0;
    end else begin
      lookup_fire <= inq_accept;
      if (inq_accept) look_line <= line_in;
      result_load <= lookup_fire;
      if (lookup_fire) begin
        res_hit <= lk_hit;
        res_mod <= lk_dirty;
        res_idx <= lk_idx;
      end
    end
  end
endmodule

// File: rtl/snoop_resp_out.sv
module snoop_resp_out #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             result_load,
  input  logic             res_hit,
  input  logic             res_mod,
  input  logic [IDX_W-1:0] res_idx,
  input  logic             wb_done,
  output logic             hit_n,
  output logic             hitm_n,
  output logic             wb_clear,
  output logic [IDX_W-1:0] pend_idx
);
  logic mod_load;
  assign mod_load = result_load && res_mod;
  assign wb_clear = wb_done && !hitm_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_n    <= 1'b1;
      hitm_n   <= 1'b1;
      pend_idx <= '0;
    end else begin
      if (result_load) hit_n <= !res_hit;
      if (mod_load) begin
        hitm_n   <= 1'b0;
        pend_idx <= res_idx;
      end else if (wb_clear) begin
        hitm_n <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/snoop_inquire_resp.sv
module snoop_inquire_resp #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inq_strobe,
  input  logic [ADDR_W-1:0] inq_addr,
  input  logic              fill_en,
  input  logic              fill_dside,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_valid,
  input  logic              fill_dirty,
  input  logic              wb_done,
  output logic              hit_n,
  output logic              hitm_n
);
  import snoop_pkg::*;

  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;

  function automatic logic [IDX_W-1:0] line_idx(input logic [LINE_W-1:0] la);
    return la[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] line_tag(input logic [LINE_W-1:0] la);
    return la[LINE_W-1:IDX_W];
  endfunction

  logic unused_offsets;
  assign unused_offsets = ^{inq_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

  logic [LINE_W-1:0] fill_line;
  assign fill_line = fill_addr[ADDR_W-1:OFF_W];

  // Events brought out for the checker.
  logic              inq_accept;
  logic              lookup_fire;
  logic              result_load;
  logic              res_hit;
  logic              res_mod;
  logic              wb_clear;
  logic [LINE_W-1:0] look_line;
  logic [IDX_W-1:0]  res_idx;
  logic [IDX_W-1:0]  pend_idx;
  logic [NUM_SIDES-1:0] side_hit;
  logic [NUM_SIDES-1:0] side_dirty;

  generate
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      snoop_tag_array #(
        .IDX_W      (IDX_W),
        .TAG_W      (TAG_W),
        .TRACK_DIRTY(s == int'(SIDE_DATA))
      ) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (fill_en && (fill_dside == s[0])),
        .wr_idx      (line_idx(fill_line)),
        .wr_tag      (line_tag(fill_line)),
        .wr_valid    (fill_valid),
        .wr_dirty    (fill_dirty),
        .clr_en      (wb_clear),
        .clr_idx     (pend_idx),
        .rd_idx      (line_idx(look_line)),
        .rd_tag      (line_tag(look_line)),
        .rd_hit      (side_hit[s]),
        .rd_hit_dirty(side_dirty[s])
      );
    end
  endgenerate

  snoop_inq_pipe #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (inq_strobe),
    .line_in    (inq_addr[ADDR_W-1:OFF_W]),
    .lk_hit     (|side_hit),
    .lk_dirty   (|side_dirty),
    .lk_idx     (line_idx(look_line)),
    .inq_accept (inq_accept),
    .lookup_fire(lookup_fire),
    .look_line  (look_line),
    .result_load(result_load),
    .res_hit    (res_hit),
    .res_mod    (res_mod),
    .res_idx    (res_idx)
  );

  snoop_resp_out #(.IDX_W(IDX_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .result_load(result_load),
    .res_hit    (res_hit),
    .res_mod    (res_mod),
    .res_idx    (res_idx),
    .wb_done    (wb_done),
    .hit_n      (hit_n),
    .hitm_n     (hitm_n),
    .wb_clear   (wb_clear),
    .pend_idx   (pend_idx)
  );
endmodule

// File: rtl/snoop_inquire_chk.sv
module snoop_inquire_chk (
  input logic clk,
  input logic rst_n,
  input logic wb_done,
  input logic inq_accept,
  input logic lookup_fire,
  input logic result_load,
  input logic res_mod,
  input logic hit_n,
  input logic hitm_n
);
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (hit_n && hitm_n)
        else $error("R1: outputs not idle during reset");
    end
  end

  a_r2_accept_to_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    inq_accept |=> lookup_fire);

  a_r3_lookup_to_result: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_fire |=> result_load);

  a_r4_hit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !result_load |=> $stable(hit_n));

  a_r5_mod_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
    (result_load && res_mod) |=> (!hitm_n && !hit_n));

  a_r6_hitm_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!hitm_n && !wb_done) |=> !hitm_n);

  a_r6_hitm_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!hitm_n && wb_done && !(result_load && res_mod)) |=> hitm_n);

  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_fire || result_load) |-> !inq_accept);

  a_r11_idle_wb_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (hitm_n && !(result_load && res_mod)) |=> hitm_n);
endmodule

bind snoop_inquire_resp snoop_inquire_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wb_done    (wb_done),
  .inq_accept (inq_accept),
  .lookup_fire(lookup_fire),
  .result_load(result_load),
  .res_mod    (res_mod),
  .hit_n      (hit_n),
  .hitm_n     (hitm_n)
);

// File: tb/snoop_inquire_resp_bench.sv
module snoop_inquire_resp_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inq_strobe = 1'b0;
  logic [31:0] inq_addr = '0;
  logic        fill_en = 1'b0;
  logic        fill_dside = 1'b0;
  logic [31:0] fill_addr = '0;
  logic        fill_valid = 1'b0;
  logic        fill_dirty = 1'b0;
  logic        wb_done = 1'b0;
  logic        hit_n;
  logic        hitm_n;

  always #(CLK_P/2) clk = ~clk;

  snoop_inquire_resp u_snoop_inquire_resp (
    .clk(clk), .rst_n(rst_n), .inq_strobe(inq_strobe), .inq_addr(inq_addr),
    .fill_en(fill_en), .fill_dside(fill_dside), .fill_addr(fill_addr),
    .fill_valid(fill_valid), .fill_dirty(fill_dirty), .wb_done(wb_done),
    .hit_n(hit_n), .hitm_n(hitm_n)
  );

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  string phase = "R1";

  // Reference model: entries keyed [side][set], set = addr[7:5], tag = addr[31:8].
  bit          m_valid [2][8];
  bit          m_dirty [8];
  int unsigned m_tag   [2][8];
  int          pipe_age = 0;
  int unsigned pipe_addr = 0;
  bit          m_hit_n = 1'b1, m_hitm_n = 1'b1;
  bit          r_hit = 1'b0, r_mod = 1'b0;
  int          r_set = 0, pend_set = 0;

  function automatic int set_of(int unsigned a); return int'((a >> 5) & 7); endfunction
  function automatic int unsigned tag_of(int unsigned a); return a >> 8; endfunction

  task automatic model_step();
    bit nhit = 1'b0, nmod = 1'b0;
    int nset = 0;
    bit deliver = (pipe_age == 2);
    bit hitm_before = m_hitm_n;
    if (pipe_age == 1) begin
      nset = set_of(pipe_addr);
      for (int s = 0; s < 2; s++)
        if (m_valid[s][nset] && m_tag[s][nset] == tag_of(pipe_addr)) nhit = 1'b1;
      nmod = m_valid[1][nset] && m_tag[1][nset] == tag_of(pipe_addr) && m_dirty[nset];
    end
    if (wb_done && !hitm_before) m_dirty[pend_set] = 1'b0;
    if (deliver) begin
      m_hit_n = !r_hit;
      if (r_mod) begin m_hitm_n = 1'b0; pend_set = r_set; end
      else if (wb_done && !hitm_before) m_hitm_n = 1'b1;
    end else if (wb_done && !hitm_before) m_hitm_n = 1'b1;
    if (fill_en) begin
      int fs = set_of(fill_addr);
      m_valid[fill_dside][fs] = fill_valid;
      m_tag[fill_dside][fs] = tag_of(fill_addr);
      if (fill_dside) m_dirty[fs] = fill_dirty && fill_valid;
    end
    if (pipe_age == 1) begin r_hit = nhit; r_mod = nmod; r_set = nset; pipe_age = 2; end
    else if (pipe_age == 2) pipe_age = 0;
    if (pipe_age == 0 && !deliver && inq_strobe) begin pipe_age = 1; pipe_addr = inq_addr; end
  endtask

  task automatic compare();
    checks++;
    if (hit_n !== m_hit_n || hitm_n !== m_hitm_n) begin
      fails++;
      $display("FAIL %s: hit_n=%b hitm_n=%b expected %b %b", phase, hit_n, hitm_n, m_hit_n, m_hitm_n);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic fill(bit dside, int unsigned a, bit v, bit d);
    fill_en = 1'b1; fill_dside = dside; fill_addr = a; fill_valid = v; fill_dirty = d;
    tick();
    fill_en = 1'b0;
  endtask

  task automatic inquire(int unsigned a);
    inq_strobe = 1'b1; inq_addr = a;
    tick();
    inq_strobe = 1'b0;
    repeat (4) tick();
  endtask

  task automatic wb_pulse();
    wb_done = 1'b1; tick(); wb_done = 1'b0; tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      finish_run();
    end
  end

  localparam int unsigned LA = 32'h0000_1020; // set 1
  localparam int unsigned LB = 32'h0000_2040; // set 2
  localparam int unsigned LC = 32'h0000_3060; // set 3
  localparam int unsigned LD = 32'h0000_7040; // set 2, other tag
  localparam int unsigned LE = 32'h0000_4080; // set 4
  localparam int unsigned LF = 32'h0000_60A0; // set 5

  initial begin
    // R1: reset state
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    repeat (2) tick();
    phase = "R1"; inquire(LA);

    fill(1'b0, LA, 1'b1, 1'b1);   // instruction side, dirty flag has no effect
    fill(1'b1, LB, 1'b1, 1'b0);   // data clean
    fill(1'b1, LC, 1'b1, 1'b1);   // data dirty

    phase = "R2"; inquire(LA);
    phase = "R3"; inquire(32'h9999_00E0);
    phase = "R2"; inquire(LB);
    phase = "R4"; repeat (6) tick();
    phase = "R8"; inquire(LA);
    phase = "R8"; inquire(LB);

    phase = "R5"; inquire(LC);
    phase = "R6"; repeat (5) tick();
    wb_pulse();
    phase = "R6"; inquire(LC);

    // R7: strobe held over busy cycles with a hitting address
    phase = "R7";
    inq_strobe = 1'b1; inq_addr = 32'h9999_00E0; tick();
    inq_addr = LC; tick(); tick();
    inq_strobe = 1'b0; repeat (4) tick();

    // R9: invalidation and replacement
    phase = "R9"; fill(1'b0, LA, 1'b0, 1'b0); inquire(LA);
    phase = "R9"; fill(1'b1, LD, 1'b1, 1'b0); inquire(LB);
    phase = "R9"; inquire(LD);

    // R10: offset bits ignored, tag compared
    phase = "R10"; fill(1'b0, LA, 1'b1, 1'b0); inquire(LA | 32'h1F);
    phase = "R10"; inquire(32'h0000_5020);

    // R11: idle wb_done, then wb_done coinciding with a new modified result
    phase = "R11"; wb_pulse();
    fill(1'b1, LE, 1'b1, 1'b1);
    fill(1'b1, LF, 1'b1, 1'b1);
    inquire(LE);
    inq_strobe = 1'b1; inq_addr = LF; tick();
    inq_strobe = 1'b0; tick();
    wb_done = 1'b1; tick();
    wb_done = 1'b0; repeat (3) tick();
    wb_pulse();
    phase = "R11"; inquire(LE);
    phase = "R11"; inquire(LF);

    finish_run();
  end
endmodule